// File: doc/BRIEF.md
# Per-Area External Bus Wait Controller

This block sets how many clock states each bus access lasts. An address decoder outside the block supplies a 3-bit index for one of eight external areas, plus two flags: one for an on-chip target and one for an area used as DRAM. The block holds three 8-bit software registers. The first is a mode byte with one bit per area; a 0 bit selects a two-state access and a 1 bit selects a three-state access. The other two bytes, high and low, hold a 2-bit inserted-wait field for each area.

An access starts with a one-cycle `acc_start` pulse while the block is idle. On the next cycle the block raises `acc_busy`. It then counts states on `acc_state`, starting at 0, and pulses `acc_done` in the last state. An external area in three-state mode also samples `ext_ready`. While that input is low in the last programmed state, the block adds one state per cycle.

On-chip targets always take two states. Areas flagged as DRAM always take three states. For both, the software registers have no effect. The registers return to all ones on a hardware reset and while hardware standby is asserted. Nothing else clears them, so their contents survive software standby.

Top module: `bus_wait_ctrl`

## Requirements
- R1: `rst` or `hw_stby`, sampled high at a clock edge, sets all three registers to 0xFF and returns the sequencer to idle (`acc_busy`=0, `acc_done`=0, `acc_state`=0).
- R2: Register select codes: 0 is the mode byte, 1 is the high wait byte, 2 is the low wait byte. `reg_wr` high at an edge writes `reg_wdata` to the selected register. `reg_rdata` shows the selected register combinationally. Select code 3 reads 0 and a write to it is dropped.
- R3: A register changes only on a write to it, R1 excepted. Its value stays the same across idle time and across accesses.
- R4: For an external, non-DRAM area whose mode bit (bit n for area n) is 0, an access lasts 2 states and the wait field is ignored.
- R5: For an external, non-DRAM area whose mode bit is 1, an access lasts 3+W states. W comes from the 16-bit word {high byte, low byte}, bits [2n+1:2n] for area n. Areas 7 to 4 are therefore in the high byte and areas 3 to 0 in the low byte.
- R6: An access with `acc_onchip`=1 lasts 2 states, whatever the registers and `acc_dram` hold.
- R7: An access with `acc_dram`=1 and `acc_onchip`=0 lasts 3 states, whatever the registers hold.
- R8: In a three-state-mode external access, each cycle the last programmed state sees `ext_ready`=0, `acc_done` is held off and `acc_state` stays unchanged, adding one state. In every other kind of access `ext_ready` has no effect.
- R9: `acc_busy` rises in the cycle after the start edge. `acc_state` reads 0,1,... up to L-1 for an L-state access, and `acc_done` is high only in the final state. In the cycle after `acc_done`, `acc_busy` is 0.
- R10: The area, flags and register settings are captured when the access starts. `acc_start` pulses and register writes that arrive while busy do not change the length of the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| hw_stby | input | 1 | Hardware standby; while high, registers are forced to 0xFF and the sequencer is held idle |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 mode, 1 wait high, 2 wait low) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| acc_start | input | 1 | Start-of-access pulse, taken only when idle |
| acc_area | input | 3 | External area index |
| acc_onchip | input | 1 | Target is on-chip |
| acc_dram | input | 1 | Area is used as DRAM |
| ext_ready | input | 1 | External ready; low requests an extra state |
| acc_busy | output | 1 | Access in progress |
| acc_state | output | 4 | Current state number within the access |
| acc_done | output | 1 | Final state of the access |

## Verification
Several rules are checked by assertions on every cycle. Hardware standby forces the registers to all ones. The registers hold their value when no write arrives. The state count advances by one each cycle until the last state. A low ready input freezes the count of a three-state access. Every `acc_done` is followed by idle. On-chip accesses always end in state 1 and DRAM accesses in state 2. The captured access settings do not change while an access runs. Other behaviour only the bench can show: the wait-field position for each area, the read mux, the exact state-by-state length against a model of the registers, and the effect of starts and writes that arrive mid-access.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
    localparam int AREAS   = 8;
    localparam int AW      = $clog2(AREAS);
    localparam int RW      = 8;
    localparam int WFW     = 2;
    localparam int STW     = 4;
    localparam int BASE2   = 2;
    localparam int BASE3   = 3;

    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_WHI   = 2'd1,
        SEL_WLO   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [RW-1:0] mode;
        logic [RW-1:0] whi;
        logic [RW-1:0] wlo;
    } cfg_t;

    typedef enum logic [1:0] {
        KIND_ONCHIP = 2'd0,
        KIND_DRAM   = 2'd1,
        KIND_TWO    = 2'd2,
        KIND_THREE  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e      kind;
        logic [WFW-1:0] waits;
    } acc_plan_t;

    localparam cfg_t CFG_RESET = '{mode: '1, whi: '1, wlo: '1};

    function automatic logic [WFW-1:0] wait_field(cfg_t c, logic [AW-1:0] area);
        logic [2*RW-1:0] word;
        word = {c.whi, c.wlo};
        return word[area*WFW +: WFW];
    endfunction

    function automatic logic [STW-1:0] last_state(acc_plan_t p);
        case (p.kind)
            KIND_ONCHIP, KIND_TWO: return STW'(BASE2 - 1);
            KIND_DRAM:             return STW'(BASE3 - 1);
            default:               return STW'(BASE3 - 1) + STW'(p.waits);
        endcase
    endfunction
endpackage

// File: rtl/bwc_regs.sv
module bwc_regs
    import bwc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          hw_stby,
    input  logic          wr,
    input  reg_sel_e      sel,
    input  logic [RW-1:0] wdata,
    output logic [RW-1:0] rdata,
    output cfg_t          cfg
);
    always_ff @(posedge clk) begin
        if (rst || hw_stby) begin
            cfg <= CFG_RESET;
        end else if (wr) begin
            case (sel)
                SEL_MODE: cfg.mode <= wdata;
                SEL_WHI:  cfg.whi  <= wdata;
                SEL_WLO:  cfg.wlo  <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_MODE: rdata = cfg.mode;
            SEL_WHI:  rdata = cfg.whi;
            SEL_WLO:  rdata = cfg.wlo;
            default:  rdata = '0;
        endcase
    end

    assert_stby_ones_R1: assert property (@(posedge clk) disable iff (rst)
        hw_stby |=> (cfg == CFG_RESET));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst || hw_stby)
        !wr |=> $stable(cfg));
endmodule

// File: rtl/bwc_plan.sv
module bwc_plan
    import bwc_pkg::*;
(
    input  cfg_t          cfg,
    input  logic [AW-1:0] area,
    input  logic          onchip,
    input  logic          dram,
    output acc_plan_t     plan
);
    logic three_sel;

    always_comb begin
        three_sel  = cfg.mode[area];
        plan.waits = '0;
        if (onchip) begin
            plan.kind = KIND_ONCHIP;
        end else if (dram) begin
            plan.kind = KIND_DRAM;
        end else if (!three_sel) begin
            plan.kind = KIND_TWO;
        end else begin
            plan.kind  = KIND_THREE;
            plan.waits = wait_field(cfg, area);
        end
    end
endmodule

// File: rtl/bwc_seq.sv
module bwc_seq
    import bwc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           hw_stby,
    input  logic           start,
    input  acc_plan_t      plan_in,
    input  logic           ext_ready,
    output logic           busy,
    output logic [STW-1:0] state,
    output logic           done
);
    acc_plan_t      plan_q;
    logic [STW-1:0] last;
    logic           at_last;
    logic           stretchable;

    always_comb begin
        last        = last_state(plan_q);
        at_last     = (state == last);
        stretchable = (plan_q.kind == KIND_THREE);
        done        = busy && at_last && (!stretchable || ext_ready);
    end

    always_ff @(posedge clk) begin
        if (rst || hw_stby) begin
            busy   <= 1'b0;
            state  <= '0;
            plan_q <= '{kind: KIND_ONCHIP, waits: '0};
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                state  <= '0;
                plan_q <= plan_in;
            end
        end else if (done) begin
            busy  <= 1'b0;
            state <= '0;
        end else if (!at_last) begin
            state <= state + 1'b1;
        end
    end

    assert_count_R9: assert property (@(posedge clk) disable iff (rst || hw_stby)
        (busy && !at_last) |=> (busy && state == STW'($past(state) + 1'b1)));

    assert_end_idle_R9: assert property (@(posedge clk) disable iff (rst || hw_stby)
        done |=> !busy);

    assert_stretch_R8: assert property (@(posedge clk) disable iff (rst || hw_stby)
        (busy && at_last && stretchable && !ext_ready) |=> (busy && $stable(state)));

    assert_onchip_len_R6: assert property (@(posedge clk) disable iff (rst || hw_stby)
        (done && plan_q.kind == KIND_ONCHIP) |-> (state == STW'(1)));

    assert_dram_len_R7: assert property (@(posedge clk) disable iff (rst || hw_stby)
        (done && plan_q.kind == KIND_DRAM) |-> (state == STW'(2)));

    assert_latched_R10: assert property (@(posedge clk) disable iff (rst || hw_stby)
        (busy && !done) |=> $stable(plan_q));
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
    import bwc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           hw_stby,
    input  logic           reg_wr,
    input  logic [1:0]     reg_sel,
    input  logic [RW-1:0]  reg_wdata,
    output logic [RW-1:0]  reg_rdata,
    input  logic           acc_start,
    input  logic [AW-1:0]  acc_area,
    input  logic           acc_onchip,
    input  logic           acc_dram,
    input  logic           ext_ready,
    output logic           acc_busy,
    output logic [STW-1:0] acc_state,
    output logic           acc_done
);
    cfg_t      cfg;
    acc_plan_t plan;
    reg_sel_e  sel;

    assign sel = reg_sel_e'(reg_sel);

    bwc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .hw_stby (hw_stby),
        .wr      (reg_wr),
        .sel     (sel),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .cfg     (cfg)
    );

    bwc_plan u_plan (
        .cfg     (cfg),
        .area    (acc_area),
        .onchip  (acc_onchip),
        .dram    (acc_dram),
        .plan    (plan)
    );

    bwc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .hw_stby   (hw_stby),
        .start     (acc_start),
        .plan_in   (plan),
        .ext_ready (ext_ready),
        .busy      (acc_busy),
        .state     (acc_state),
        .done      (acc_done)
    );
endmodule

// File: tb/sim_bus_wait_ctrl.sv
module sim_bus_wait_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hw_stby = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       acc_start = 1'b0;
    logic [2:0] acc_area = 3'd0;
    logic       acc_onchip = 1'b0;
    logic       acc_dram = 1'b0;
    logic       ext_ready = 1'b1;
    logic       acc_busy;
    logic [3:0] acc_state;
    logic       acc_done;

    int errors = 0;
    int checks = 0;
    logic [7:0] m_mode = 8'hFF, m_whi = 8'hFF, m_wlo = 8'hFF;

    always #10 clk = ~clk;

    bus_wait_ctrl u0 (
        .clk(clk), .rst(rst), .hw_stby(hw_stby),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_start(acc_start), .acc_area(acc_area), .acc_onchip(acc_onchip),
        .acc_dram(acc_dram), .ext_ready(ext_ready),
        .acc_busy(acc_busy), .acc_state(acc_state), .acc_done(acc_done)
    );

    function automatic int exp_len(logic [2:0] a, logic on, logic dr);
        logic [15:0] word;
        word = {m_whi, m_wlo};
        if (on) return 2;
        if (dr) return 3;
        if (!m_mode[a]) return 2;
        return 3 + int'(word[a*2 +: 2]);
    endfunction

    function automatic logic [7:0] model_rd(logic [1:0] s);
        case (s)
            2'd0: return m_mode;
            2'd1: return m_whi;
            2'd2: return m_wlo;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (s)
            2'd0: m_mode = d;
            2'd1: m_whi = d;
            2'd2: m_wlo = d;
            default: ;
        endcase
    endtask

    task automatic rd_check(input logic [1:0] s, input string req);
        reg_sel = s;
        #1;
        check(reg_rdata === model_rd(s), req, "register read", reg_rdata, model_rd(s));
    endtask

    task automatic run_access(input logic [2:0] a, input logic on, input logic dr,
                              input int stretch, input logic low_all, input logic poke,
                              input string req);
        int  len;
        bit  three;
        int  es;
        bit  ed;
        len   = exp_len(a, on, dr);
        three = !on && !dr && m_mode[a];
        if (!three) stretch = 0;
        @(negedge clk);
        acc_area = a; acc_onchip = on; acc_dram = dr; acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
        for (int c = 0; c < len + stretch; c++) begin
            if (poke && c == 0) begin
                acc_start = 1'b1; acc_onchip = 1'b1;
                reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h00;
            end else if (poke && c == 1) begin
                acc_start = 1'b0; reg_wr = 1'b0; m_mode = 8'h00;
            end
            if (three) ext_ready = !(c >= len - 1 && c < len - 1 + stretch);
            else       ext_ready = !low_all;
            #1;
            es = (c < len - 1) ? c : len - 1;
            ed = (c >= len - 1 + stretch);
            check(acc_busy === 1'b1 && acc_state === 4'(es) && acc_done === ed, req,
                  "busy/state/done", {acc_busy, acc_state, acc_done}, {1'b1, 4'(es), ed});
            @(negedge clk);
        end
        ext_ready = 1'b1;
        #1;
        check(acc_busy === 1'b0 && acc_done === 1'b0, req, "idle after access",
              {acc_busy, acc_done}, 0);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(acc_busy === 1'b0 && acc_done === 1'b0 && acc_state === 4'd0, "R1",
              "idle after reset", {acc_busy, acc_state, acc_done}, 0);
        rd_check(2'd0, "R1"); rd_check(2'd1, "R1"); rd_check(2'd2, "R1");

        // R2 read/write and unused select
        wr_reg(2'd0, 8'h5A); wr_reg(2'd1, 8'hC3); wr_reg(2'd2, 8'h1E);
        wr_reg(2'd3, 8'h77);
        rd_check(2'd0, "R2"); rd_check(2'd1, "R2"); rd_check(2'd2, "R2"); rd_check(2'd3, "R2");

        // R4 all two-state, waits ignored
        wr_reg(2'd0, 8'h00); wr_reg(2'd1, 8'hFF); wr_reg(2'd2, 8'hFF);
        for (int a = 0; a < 8; a++) run_access(3'(a), 1'b0, 1'b0, 0, 1'b1, 1'b0, "R4");

        // R5 wait field mapping per area, distinct waits
        wr_reg(2'd0, 8'hFF); wr_reg(2'd1, 8'b00_01_10_11); wr_reg(2'd2, 8'b11_10_01_00);
        for (int a = 0; a < 8; a++) run_access(3'(a), 1'b0, 1'b0, 0, 1'b0, 1'b0, "R5");

        // R6 on-chip ignores everything, R7 DRAM ignores settings
        run_access(3'd7, 1'b1, 1'b1, 2, 1'b1, 1'b0, "R6");
        run_access(3'd0, 1'b1, 1'b0, 0, 1'b1, 1'b0, "R6");
        run_access(3'd3, 1'b0, 1'b1, 0, 1'b1, 1'b0, "R7");
        wr_reg(2'd0, 8'h00);
        run_access(3'd3, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R7");

        // R8 stretch in three-state mode; ignored in two-state
        wr_reg(2'd0, 8'h0F);
        run_access(3'd0, 1'b0, 1'b0, 3, 1'b0, 1'b0, "R8");
        run_access(3'd6, 1'b0, 1'b0, 0, 1'b1, 1'b0, "R8");
        run_access(3'd2, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R8");

        // R10 start and write while busy do not alter running access
        wr_reg(2'd0, 8'hFF);
        run_access(3'd4, 1'b0, 1'b0, 0, 1'b0, 1'b1, "R10");
        rd_check(2'd0, "R10");
        run_access(3'd4, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R10");

        // R3 retention across idle time and accesses
        wr_reg(2'd0, 8'hA5); wr_reg(2'd1, 8'h3C); wr_reg(2'd2, 8'h96);
        repeat (7) @(negedge clk);
        run_access(3'd5, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R9");
        rd_check(2'd0, "R3"); rd_check(2'd1, "R3"); rd_check(2'd2, "R3");

        // Random mix (R9 timing against model)
        for (int i = 0; i < 120; i++) begin
            if ($urandom % 4 == 0) wr_reg(2'($urandom % 4), 8'($urandom));
            if ($urandom % 5 == 0) rd_check(2'($urandom % 4), "R2");
            run_access(3'($urandom % 8), ($urandom % 6) == 0, ($urandom % 5) == 0,
                       int'($urandom % 3), 1'($urandom), 1'b0, "R9");
        end

        // R1 hardware standby restores all ones and idles sequencer
        wr_reg(2'd0, 8'h12); wr_reg(2'd1, 8'h34); wr_reg(2'd2, 8'h56);
        @(negedge clk);
        hw_stby = 1'b1;
        @(negedge clk);
        hw_stby = 1'b0;
        m_mode = 8'hFF; m_whi = 8'hFF; m_wlo = 8'hFF;
        rd_check(2'd0, "R1"); rd_check(2'd1, "R1"); rd_check(2'd2, "R1");
        run_access(3'd1, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule